// File: doc/BRIEF.md
# Latched Parity Bus Transceiver

This block links two 9-bit buses, A and B. Each word has 8 data bits in bits 7:0 and a parity bit in bit 8. Each direction has its own capture stage. The A-side stage takes words from bus A and forwards them to bus B. The B-side stage takes words from bus B and forwards them to bus A. The two directions behave the same way.

Each capture stage is a transparent latch built for a clocked core. While its enable is high, the stage passes the incoming word straight through in the same cycle. It also records that word at every rising clock edge. While the enable is low, the stage presents the word it recorded at the last rising edge where the enable was high.

A feed-through select decides the parity bit that is forwarded. The forwarded bit is either the received parity bit or parity generated from the 8 latched data bits. A polarity select chooses odd or even parity for both generation and checking.

Two active-low error flags report parity faults in the contents of the two stages at all times, whatever the output enables are set to. Tri-state pins are modelled as separate enable and data outputs.

Top module: `pbx_transceiver`

## Requirements
- R1: While `le_a` is 1, bits 7:0 forwarded to bus B equal `a_in[7:0]` in the same cycle. While `le_b` is 1, bits 7:0 forwarded to bus A equal `b_in[7:0]` in the same cycle.
- R2: While a stage's enable is 0, it presents the word it captured at the last rising clock edge where its enable was 1, whatever its bus input does.
- R3: When `sel_feed` is 0, bit 8 of each forwarded word is generated so that the XOR of all 9 bits is 1 when `odd_sel` is 1 and 0 when `odd_sel` is 0.
- R4: When `sel_feed` is 1, bit 8 of each forwarded word equals bit 8 of the stage contents it comes from.
- R5: `err_a_n` is 0 exactly when the A-side stage contents fail the parity check. `err_b_n` is 0 exactly when the B-side stage contents fail it. A word fails when the XOR of its 9 bits is 0 with `odd_sel` = 1, or is 1 with `odd_sel` = 0. Both flags stay valid while both output enables are off.
- R6: `b_oe` = 1 exactly when `oe_b_n` = 0. `a_oe` = 1 exactly when `oe_a_n` = 0 and `oe_b_n` = 1, so bus B wins when both enables are requested. An output whose enable is 0 drives all zeros.
- R7: Reset clears both stages to the all-zero word.
- R8: The two stages capture independently. Any mix of the two enables is legal, and capturing on one side never changes the other side.
- R9: The B-to-A path behaves identically to the A-to-B path, using `b_in`, `le_b`, `err_b_n` and the bus A outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_in | input | 9 | Word received from bus A (bit 8 parity) |
| b_in | input | 9 | Word received from bus B (bit 8 parity) |
| le_a | input | 1 | A-side stage enable (1 = transparent) |
| le_b | input | 1 | B-side stage enable (1 = transparent) |
| sel_feed | input | 1 | 1 = forward received parity, 0 = substitute generated parity |
| odd_sel | input | 1 | 1 = odd parity, 0 = even parity |
| oe_a_n | input | 1 | Active-low request to drive bus A |
| oe_b_n | input | 1 | Active-low request to drive bus B |
| a_out | output | 9 | Word driven onto bus A |
| a_oe | output | 1 | Bus A driver enable |
| b_out | output | 9 | Word driven onto bus B |
| b_oe | output | 1 | Bus B driver enable |
| err_a_n | output | 1 | Active-low parity fault on A-side stage contents |
| err_b_n | output | 1 | Active-low parity fault on B-side stage contents |

## Verification
The hardest case to reach is a held word that carries a bad parity bit while its bus input has since changed to a clean word. In that state the error flag must follow the stored word and not the live input. The bench reaches it in three steps. It captures a word with one bit flipped, drops the enable, and then drives a correct word on the same bus. It repeats this for every bit position and for both parity polarities. Random stimulus then mixes all enable and select combinations against a cycle-tracking model of the two stages.

// File: rtl/pbx_pkg.sv
package pbx_pkg;
    parameter int PBX_DATA_W = 8;
    parameter int PBX_LANES  = 2;

    typedef enum logic {
        LANE_A = 1'b0,
        LANE_B = 1'b1
    } pbx_lane_e;
endpackage

// File: rtl/pbx_parity_unit.sv
module pbx_parity_unit #(
    parameter int DATA_W = pbx_pkg::PBX_DATA_W
) (
    input  logic [DATA_W-1:0] data_in,
    input  logic              par_in,
    input  logic              odd_sel,
    output logic              gen_par,
    output logic              fail
);
    logic data_xor;

    always_comb begin
        data_xor = ^data_in;
        // generated bit makes the 9-bit XOR equal odd_sel
        gen_par  = data_xor ^ odd_sel;
        // word fails when its 9-bit XOR disagrees with the polarity
        fail     = (data_xor ^ par_in) != odd_sel;
    end
endmodule

// File: rtl/pbx_lane.sv
module pbx_lane #(
    parameter int DATA_W = pbx_pkg::PBX_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W:0]   in_word,
    input  logic              le,
    input  logic              sel_feed,
    input  logic              odd_sel,
    output logic [DATA_W:0]   fwd_word,
    output logic              err_n
);
    localparam int WORD_W = DATA_W + 1;
    localparam int PAR_BIT = DATA_W;

    typedef struct packed {
        logic [WORD_W-1:0] held;
    } lane_st_t;

    lane_st_t          st_d, st_q;
    logic [WORD_W-1:0] view_word;
    logic              gen_par;
    logic              chk_fail;

    always_comb begin
        st_d = st_q;
        if (le) begin
            st_d.held = in_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign view_word = le ? in_word : st_q.held;

    pbx_parity_unit #(.DATA_W(DATA_W)) par_i (
        .data_in (view_word[DATA_W-1:0]),
        .par_in  (view_word[PAR_BIT]),
        .odd_sel (odd_sel),
        .gen_par (gen_par),
        .fail    (chk_fail)
    );

    always_comb begin
        fwd_word[DATA_W-1:0] = view_word[DATA_W-1:0];
        fwd_word[PAR_BIT]    = sel_feed ? view_word[PAR_BIT] : gen_par;
        err_n                = ~chk_fail;
    end

    AST_GEN_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_feed |-> ((^fwd_word) == odd_sel)); // R3
    AST_FEED_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        sel_feed |-> (fwd_word[PAR_BIT] == view_word[PAR_BIT])); // R4
    AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && $past(!le) && $stable(odd_sel)) |-> $stable(err_n)); // R5
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (st_q.held == '0)); // R7
endmodule

// File: rtl/pbx_drive_arb.sv
module pbx_drive_arb #(
    parameter int WORD_W = pbx_pkg::PBX_DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              oe_a_n,
    input  logic              oe_b_n,
    input  logic [WORD_W-1:0] word_to_a,
    input  logic [WORD_W-1:0] word_to_b,
    output logic [WORD_W-1:0] a_out,
    output logic              a_oe,
    output logic [WORD_W-1:0] b_out,
    output logic              b_oe
);
    always_comb begin
        b_oe  = ~oe_b_n;
        // bus B wins when both drivers are requested
        a_oe  = ~oe_a_n & oe_b_n;
        b_out = b_oe ? word_to_b : '0;
        a_out = a_oe ? word_to_a : '0;
    end

    AST_SINGLE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_oe && b_oe)); // R6
    AST_IDLE_QUIET_A: assert property (@(posedge clk) disable iff (!rst_n)
        !a_oe |-> (a_out == '0)); // R6
    AST_IDLE_QUIET_B: assert property (@(posedge clk) disable iff (!rst_n)
        !b_oe |-> (b_out == '0)); // R6
endmodule

// File: rtl/pbx_transceiver.sv
module pbx_transceiver #(
    parameter int DATA_W = pbx_pkg::PBX_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W:0]   a_in,
    input  logic [DATA_W:0]   b_in,
    input  logic              le_a,
    input  logic              le_b,
    input  logic              sel_feed,
    input  logic              odd_sel,
    input  logic              oe_a_n,
    input  logic              oe_b_n,
    output logic [DATA_W:0]   a_out,
    output logic              a_oe,
    output logic [DATA_W:0]   b_out,
    output logic              b_oe,
    output logic              err_a_n,
    output logic              err_b_n
);
    import pbx_pkg::*;

    localparam int WORD_W = DATA_W + 1;
    localparam int LANES  = PBX_LANES;

    logic [WORD_W-1:0] lane_in  [LANES];
    logic [WORD_W-1:0] lane_fwd [LANES];
    logic              lane_le  [LANES];
    logic              lane_err [LANES];

    always_comb begin
        lane_in[LANE_A] = a_in;
        lane_in[LANE_B] = b_in;
        lane_le[LANE_A] = le_a;
        lane_le[LANE_B] = le_b;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pbx_lane #(.DATA_W(DATA_W)) lane_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_word  (lane_in[g]),
            .le       (lane_le[g]),
            .sel_feed (sel_feed),
            .odd_sel  (odd_sel),
            .fwd_word (lane_fwd[g]),
            .err_n    (lane_err[g])
        );
    end

    assign err_a_n = lane_err[LANE_A];
    assign err_b_n = lane_err[LANE_B];

    pbx_drive_arb #(.WORD_W(WORD_W)) arb_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .oe_a_n    (oe_a_n),
        .oe_b_n    (oe_b_n),
        .word_to_a (lane_fwd[LANE_B]),
        .word_to_b (lane_fwd[LANE_A]),
        .a_out     (a_out),
        .a_oe      (a_oe),
        .b_out     (b_out),
        .b_oe      (b_oe)
    );

    AST_PASS_A2B: assert property (@(posedge clk) disable iff (!rst_n)
        (le_a && !oe_b_n) |-> (b_out[DATA_W-1:0] == a_in[DATA_W-1:0])); // R1
    AST_PASS_B2A: assert property (@(posedge clk) disable iff (!rst_n)
        (le_b && a_oe) |-> (a_out[DATA_W-1:0] == b_in[DATA_W-1:0])); // R9
    AST_HOLD_A2B: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_a && $past(!le_a) && !oe_b_n && $stable(oe_b_n)
         && $stable(sel_feed) && $stable(odd_sel)) |-> $stable(b_out)); // R2
endmodule

// File: tb/pbx_transceiver_tb_top.sv
`timescale 1ns/1ps
module pbx_transceiver_tb_top;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DW:0] a_in = '0, b_in = '0;
    logic le_a = 1'b0, le_b = 1'b0, sel_feed = 1'b0, odd_sel = 1'b0;
    logic oe_a_n = 1'b1, oe_b_n = 1'b1;
    logic [DW:0] a_out, b_out;
    logic a_oe, b_oe, err_a_n, err_b_n;

    int n_chk = 0;
    int n_fail = 0;
    logic [DW:0] ref_a, ref_b;

    always #10 clk = ~clk;

    pbx_transceiver #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .le_a(le_a), .le_b(le_b), .sel_feed(sel_feed), .odd_sel(odd_sel),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .a_out(a_out), .a_oe(a_oe),
        .b_out(b_out), .b_oe(b_oe), .err_a_n(err_a_n), .err_b_n(err_b_n)
    );

    // model of the two capture stages
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_a <= '0;
            ref_b <= '0;
        end else begin
            if (le_a) ref_a <= a_in;
            if (le_b) ref_b <= b_in;
        end
    end

    function automatic logic [DW:0] fwd(input logic [DW:0] w);
        logic p;
        p = sel_feed ? w[DW] : ((^w[DW-1:0]) ^ odd_sel);
        return {p, w[DW-1:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string ctx);
        logic [DW:0] va, vb, eb, ea;
        logic exp_aoe, exp_boe;
        va = le_a ? a_in : ref_a;
        vb = le_b ? b_in : ref_b;
        exp_boe = !oe_b_n;
        exp_aoe = !oe_a_n && oe_b_n;
        eb = exp_boe ? fwd(va) : '0;
        ea = exp_aoe ? fwd(vb) : '0;
        chk({ctx, le_a ? " R1 b data" : " R2 b data"}, b_out[DW-1:0], eb[DW-1:0]);
        chk({ctx, sel_feed ? " R4 b par" : " R3 b par"}, b_out[DW], eb[DW]);
        chk({ctx, " R9 a data"}, a_out[DW-1:0], ea[DW-1:0]);
        chk({ctx, sel_feed ? " R4 a par" : " R3 a par"}, a_out[DW], ea[DW]);
        chk({ctx, " R6 b_oe"}, b_oe, exp_boe);
        chk({ctx, " R6 a_oe"}, a_oe, exp_aoe);
        chk({ctx, " R5 err_a"}, err_a_n, (^va) == odd_sel);
        chk({ctx, " R5 err_b"}, err_b_n, (^vb) == odd_sel);
    endtask

    task automatic drive(input logic [DW:0] a, input logic [DW:0] b, input logic la,
                         input logic lb, input logic sf, input logic od,
                         input logic oa, input logic ob);
        @(negedge clk);
        a_in = a; b_in = b; le_a = la; le_b = lb;
        sel_feed = sf; odd_sel = od; oe_a_n = oa; oe_b_n = ob;
        #2;
    endtask

    task automatic t_reset;  // R7
        @(negedge clk);
        chk("R7 reset b_oe", b_oe, 1'b0);
        chk("R7 reset a_oe", a_oe, 1'b0);
        drive('0, '0, 0, 0, 0, 0, 1, 0);
        chk("R7 cleared A stage", b_out, '0);
        drive('0, '0, 0, 0, 0, 1, 1, 0);
        chk("R7 zero word odd fault", err_a_n, 1'b0);
        compare_all("R7");
    endtask

    task automatic t_transparent;  // R1 R9
        drive(9'h0A5, 9'h13C, 1, 1, 0, 1, 1, 0);
        chk("R1 pass a->b", b_out[DW-1:0], 8'hA5);
        compare_all("R1");
        drive(9'h0A5, 9'h13C, 1, 1, 0, 1, 0, 1);
        chk("R9 pass b->a", a_out[DW-1:0], 8'h3C);
        compare_all("R9");
    endtask

    task automatic t_hold;  // R2 R8
        drive(9'h155, 9'h0F0, 1, 0, 1, 0, 1, 0);
        drive(9'h022, 9'h1FF, 0, 1, 1, 0, 1, 0);
        chk("R2 held A word", b_out, 9'h155);
        compare_all("R8 mix");
        drive(9'h0EE, 9'h011, 0, 0, 1, 0, 0, 1);
        chk("R8 B held own word", a_out, 9'h1FF);
        compare_all("R2 both held");
        drive(9'h0EE, 9'h011, 0, 0, 1, 0, 1, 0);
        chk("R8 A unaffected by B", b_out, 9'h155);
    endtask

    task automatic t_parity;  // R3 R4
        for (int od = 0; od < 2; od++) begin
            drive(9'h1C3, 9'h007, 1, 1, 0, od[0], 1, 0);
            chk("R3 generated parity", ^b_out, od[0]);
            compare_all("R3");
            drive(9'h1C3, 9'h007, 1, 1, 1, od[0], 1, 0);
            chk("R4 fed-through parity", b_out[DW], 1'b1);
            compare_all("R4");
        end
    endtask

    task automatic t_faults;  // R5
        for (int od = 0; od < 2; od++) begin
            for (int bit_i = 0; bit_i <= DW; bit_i++) begin
                logic [DW:0] good, bad;
                good = 9'h05A;
                good[DW] = (^good[DW-1:0]) ^ od[0];
                bad = good ^ (9'h1 << bit_i);
                drive(bad, bad, 1, 1, 1, od[0], 1, 1);
                chk("R5 live fault A", err_a_n, 1'b0);
                drive(good, good, 0, 0, 1, od[0], 1, 1);
                chk("R5 held fault A", err_a_n, 1'b0);
                chk("R5 held fault B", err_b_n, 1'b0);
                drive(good, good, 1, 1, 1, od[0], 1, 1);
                chk("R5 clean A", err_a_n, 1'b1);
                compare_all("R5");
            end
        end
    endtask

    task automatic t_oe;  // R6
        for (int k = 0; k < 4; k++) begin
            drive(9'h1A1, 9'h04E, 1, 1, 1, 0, k[0], k[1]);
            compare_all("R6");
        end
        drive(9'h1A1, 9'h04E, 1, 1, 1, 0, 0, 0);
        chk("R6 both requested a_oe", a_oe, 1'b0);
        chk("R6 both requested a_out", a_out, '0);
    endtask

    task automatic t_random;  // R1 R2 R3 R4 R5 R6 R8
        for (int i = 0; i < 400; i++) begin
            drive(DW'($urandom) | ($urandom & 1) << DW, 9'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            compare_all("random");
        end
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_transparent();
        t_hold();
        t_parity();
        t_faults();
        t_oe();
        t_random();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule